// File: doc/BRIEF.md
# CEC Controller Host Mailbox Register File

This block is the register file that a host processor sees in front of an HDMI-CEC message controller. The host reaches it over a simple synchronous register bus with 8-bit addresses and 8-bit data. Read data is combinational from the address. Read side effects and writes take place on the clock edge where the strobe is high. On the other side sits the CEC line engine, which handles bit timing on the wire. The engine fetches outgoing payload bytes from the transmit mailbox. It writes incoming bytes into the receive mailbox, commits a finished message, and reports transmit completion with a one-bit acknowledge result.

The block also does the following:
- It latches six event sources into a write-one-to-clear status register.
- It gates that status register with an enable register and drives a level interrupt.
- It holds a logical-address nibble, a mode register, a fixed identification byte and a 16-bit physical address.

Lengths are always held as length minus one. Transmit and receive transfers are honoured only after the host has switched the mode register out of its power-up automatic value.

Top module: `cec_mbox_regs`

## Requirements
- R1: After reset the following hold. Transmit control (0x00) reads 0x80. Mode (0x11) reads 0x78. Interrupt enable (0x1B) reads 0x80. Status (0x3E) reads 0x00. Receive control (0x40) reads 0x00. ID (0x51) reads 0x5B. Logical address (0x34) reads 0xF0. irq_o and tx_req_o are low.
- R2: Mailbox transfers need host mode, which is mode value 0xB5. In any other mode the following are ignored: a length write to 0x00, payload writes, and the reads that clear the receive flag.
- R3: At 0x00, bit 7 = transmit buffer free, bit 6 = acknowledge result, bits 3:0 = length minus one. In host mode with the buffer free, a write to 0x00 stores wdata[3:0] and clears bit 7. tx_req_o rises only after the payload byte at address 0x01+code is written. While tx_req_o is high, tx_len_o gives the code and tx_byte_o returns the byte written at 0x01+tx_idx_i.
- R4: A write to 0x00 while the buffer is not free leaves the stored length unchanged.
- R5: A tx_done_i pulse while tx_req_o is high does three things on the same edge. It stores tx_ack_i into bit 6, sets bit 7 and drops tx_req_o. It also sets status bit 2.
- R6: At 0x40, bit 7 = message available, bits 3:0 = length minus one. The payload reads at 0x41 to 0x50. rx_commit_i with no message pending sets bit 7, stores rx_len_i and sets status bit 2+1 (bit 3).
- R7: The available flag clears only once every one of the 16 receive locations 0x41 to 0x50 has been read by a strobe in host mode. Repeated reads of one location count once. The length field is kept.
- R8: rx_commit_i while a message is pending is dropped. The pending length and bytes are unchanged, and status bit 0 (error) is set.
- R9: Status bits are 5 = hot-plug fall, 4 = hot-plug rise, 3 = message received, 2 = transmit finished, 1 = new physical address, 0 = error. Writing 1 to a bit clears it. An event on the same edge as its clear leaves the bit set.
- R10: irq_o is high exactly when a status bit is set whose enable bit (same position at 0x1B) is 1. A value of 0x80 masks all sources, and 0xFF enables all of them.
- R11: A write to 0x34 changes only bits 7:4, which drive la_o. Bits 3:0 keep their value.
- R12: pa_upd_i loads pa_i. The high byte reads at 0x53 and the low byte at 0x54, and the update sets status bit 1. hpd_rise_i and hpd_fall_i set bits 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (read side effects) |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Level interrupt |
| la_o | output | 4 | Logical address to line engine |
| tx_req_o | output | 1 | Transmit request to line engine |
| tx_len_o | output | LEN_W | Transmit length minus one |
| tx_idx_i | input | LEN_W | Engine payload fetch index |
| tx_byte_o | output | 8 | Payload byte at tx_idx_i |
| tx_done_i | input | 1 | Engine transmit completion pulse |
| tx_ack_i | input | 1 | Acknowledge result with tx_done_i |
| rx_wr_i | input | 1 | Engine receive byte write |
| rx_idx_i | input | LEN_W | Receive byte index |
| rx_byte_i | input | 8 | Receive byte |
| rx_commit_i | input | 1 | Engine message complete |
| rx_len_i | input | LEN_W | Received length minus one |
| hpd_rise_i | input | 1 | Hot-plug rise event |
| hpd_fall_i | input | 1 | Hot-plug fall event |
| pa_upd_i | input | 1 | Physical address update |
| pa_i | input | 16 | New physical address |

## Verification
The bench goes after the following corner cases of the receive flag:
- A short message must not clear the flag early. A design that cleared it on reading the message length, or on the last payload byte, would lose the flag after a few reads.
- Hammering one receive location sixteen times must not count as sixteen distinct reads.

It also covers these cases:
- A length write during a pending transmission, which a careless design would let corrupt the length.
- A second commit while a message is pending, which would overwrite data instead of raising the error bit.
- A clear that coincides with an event, where a clear-priority design drops the event.
- A logical-address write that would wipe the low nibble.
- Mailbox writes in automatic mode, which must be ignored.

// File: rtl/cec_mbox_pkg.sv
package cec_mbox_pkg;
  localparam logic [7:0] A_TXCTL = 8'h00;
  localparam logic [7:0] A_TXBUF = 8'h01;
  localparam logic [7:0] A_MODE  = 8'h11;
  localparam logic [7:0] A_IEN   = 8'h1B;
  localparam logic [7:0] A_LADDR = 8'h34;
  localparam logic [7:0] A_ISTAT = 8'h3E;
  localparam logic [7:0] A_RXCTL = 8'h40;
  localparam logic [7:0] A_RXBUF = 8'h41;
  localparam logic [7:0] A_ID    = 8'h51;
  localparam logic [7:0] A_PAH   = 8'h53;
  localparam logic [7:0] A_PAL   = 8'h54;

  localparam logic [7:0] MODE_AUTO = 8'h78;
  localparam logic [7:0] MODE_HOST = 8'hB5;
  localparam logic [7:0] IEN_RST   = 8'h80;

  localparam int EV_W      = 6;
  localparam int EV_ERR    = 0;
  localparam int EV_NEWPA  = 1;
  localparam int EV_TXDONE = 2;
  localparam int EV_RXMSG  = 3;
  localparam int EV_HPDR   = 4;
  localparam int EV_HPDF   = 5;

  typedef logic [EV_W-1:0] ev_t;
endpackage

// File: rtl/cec_mbox_tx.sv
module cec_mbox_tx #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_i,
  input  logic             ctl_wr_i,
  input  logic             buf_wr_i,
  input  logic [LEN_W-1:0] buf_idx_i,
  input  logic [7:0]       wdata_i,
  input  logic             done_i,
  input  logic             ack_i,
  input  logic [LEN_W-1:0] eng_idx_i,
  output logic [7:0]       eng_byte_o,
  output logic             req_o,
  output logic [LEN_W-1:0] len_o,
  output logic             free_o,
  output logic             ack_o,
  output logic             fin_o
);
  logic [7:0]       buf_q [DEPTH];
  logic             free_q, req_q, ack_q;
  logic [LEN_W-1:0] len_q;
  logic             fill;

  // payload accepted only between length write and request
  assign fill  = host_i && buf_wr_i && !free_q && !req_q;
  assign fin_o = req_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= 1'b1;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      if (host_i && ctl_wr_i && free_q) begin
        len_q  <= wdata_i[LEN_W-1:0];
        free_q <= 1'b0;
      end
      if (fill && buf_idx_i == len_q) req_q <= 1'b1;
      if (fin_o) begin
        req_q  <= 1'b0;
        free_q <= 1'b1;
        ack_q  <= ack_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill) buf_q[buf_idx_i] <= wdata_i;
  end

  assign eng_byte_o = buf_q[eng_idx_i];
  assign req_o      = req_q;
  assign len_o      = len_q;
  assign free_o     = free_q;
  assign ack_o      = ack_q;
endmodule

// File: rtl/cec_mbox_rx.sv
module cec_mbox_rx #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_i,
  input  logic             rd_buf_i,
  input  logic [LEN_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o,
  input  logic             eng_wr_i,
  input  logic [LEN_W-1:0] eng_idx_i,
  input  logic [7:0]       eng_byte_i,
  input  logic             commit_i,
  input  logic [LEN_W-1:0] commit_len_i,
  output logic             valid_o,
  output logic [LEN_W-1:0] len_o,
  output logic             got_o,
  output logic             drop_o
);
  logic [7:0]       buf_q [DEPTH];
  logic             valid_q;
  logic [LEN_W-1:0] len_q;
  logic [DEPTH-1:0] seen_q, hit, seen_nxt;

  assign hit      = {{(DEPTH-1){1'b0}}, 1'b1} << rd_idx_i;
  assign seen_nxt = seen_q | hit;
  assign got_o    = commit_i && !valid_q;
  assign drop_o   = commit_i && valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      len_q   <= '0;
      seen_q  <= '0;
    end else if (got_o) begin
      valid_q <= 1'b1;
      len_q   <= commit_len_i;
      seen_q  <= '0;
    end else if (host_i && rd_buf_i && valid_q) begin
      // flag drops only once every location has been read
      if (&seen_nxt) begin
        valid_q <= 1'b0;
        seen_q  <= '0;
      end else begin
        seen_q  <= seen_nxt;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (eng_wr_i && !valid_q) buf_q[eng_idx_i] <= eng_byte_i;
  end

  assign rd_byte_o = buf_q[rd_idx_i];
  assign valid_o   = valid_q;
  assign len_o     = len_q;
endmodule

// File: rtl/cec_mbox_irq.sv
module cec_mbox_irq
  import cec_mbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ev_t        ev_i,
  input  logic       clr_wr_i,
  input  ev_t        clr_i,
  input  logic       en_wr_i,
  input  logic [7:0] en_i,
  output ev_t        stat_o,
  output logic [7:0] en_o,
  output logic       irq_o
);
  ev_t        stat_q;
  logic [7:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= IEN_RST;
    end else begin
      // set wins over a simultaneous clear
      stat_q <= (stat_q & ~(clr_wr_i ? clr_i : '0)) | ev_i;
      if (en_wr_i) en_q <= en_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q[EV_W-1:0]);
endmodule

// File: rtl/cec_mbox_regs.sv
module cec_mbox_regs
  import cec_mbox_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter logic [7:0] ID_VAL    = 8'h5B,
  parameter logic [7:0] LADDR_RST = 8'hF0,
  localparam int        LEN_W     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o,
  output logic [3:0]       la_o,
  output logic             tx_req_o,
  output logic [LEN_W-1:0] tx_len_o,
  input  logic [LEN_W-1:0] tx_idx_i,
  output logic [7:0]       tx_byte_o,
  input  logic             tx_done_i,
  input  logic             tx_ack_i,
  input  logic             rx_wr_i,
  input  logic [LEN_W-1:0] rx_idx_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_commit_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             hpd_rise_i,
  input  logic             hpd_fall_i,
  input  logic             pa_upd_i,
  input  logic [15:0]      pa_i
);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic [7:0]       mode_q, laddr_q;
  logic [15:0]      pa_q;
  logic             host;
  logic [7:0]       tx_off, rx_off;
  logic             in_tx, in_rx;
  logic             tx_free, tx_ack, tx_fin;
  logic [7:0]       rx_byte;
  logic             rx_valid, rx_got, rx_drop;
  logic [LEN_W-1:0] rx_len;
  ev_t              ev, irq_stat;
  logic [7:0]       irq_en;

  assign host   = (mode_q == MODE_HOST);
  assign tx_off = addr_i - A_TXBUF;
  assign rx_off = addr_i - A_RXBUF;
  assign in_tx  = tx_off < DEPTH8;
  assign in_rx  = rx_off < DEPTH8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_AUTO;
      laddr_q <= LADDR_RST;
      pa_q    <= '0;
    end else begin
      if (wr_i && addr_i == A_MODE)  mode_q <= wdata_i;
      if (wr_i && addr_i == A_LADDR) laddr_q[7:4] <= wdata_i[7:4];
      if (pa_upd_i) pa_q <= pa_i;
    end
  end

  cec_mbox_tx #(.DEPTH(DEPTH)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_i     (host),
    .ctl_wr_i   (wr_i && addr_i == A_TXCTL),
    .buf_wr_i   (wr_i && in_tx),
    .buf_idx_i  (tx_off[LEN_W-1:0]),
    .wdata_i    (wdata_i),
    .done_i     (tx_done_i),
    .ack_i      (tx_ack_i),
    .eng_idx_i  (tx_idx_i),
    .eng_byte_o (tx_byte_o),
    .req_o      (tx_req_o),
    .len_o      (tx_len_o),
    .free_o     (tx_free),
    .ack_o      (tx_ack),
    .fin_o      (tx_fin)
  );

  cec_mbox_rx #(.DEPTH(DEPTH)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_i       (host),
    .rd_buf_i     (rd_i && in_rx),
    .rd_idx_i     (rx_off[LEN_W-1:0]),
    .rd_byte_o    (rx_byte),
    .eng_wr_i     (rx_wr_i),
    .eng_idx_i    (rx_idx_i),
    .eng_byte_i   (rx_byte_i),
    .commit_i     (rx_commit_i),
    .commit_len_i (rx_len_i),
    .valid_o      (rx_valid),
    .len_o        (rx_len),
    .got_o        (rx_got),
    .drop_o       (rx_drop)
  );

  always_comb begin
    ev            = '0;
    ev[EV_ERR]    = rx_drop;
    ev[EV_NEWPA]  = pa_upd_i;
    ev[EV_TXDONE] = tx_fin;
    ev[EV_RXMSG]  = rx_got;
    ev[EV_HPDR]   = hpd_rise_i;
    ev[EV_HPDF]   = hpd_fall_i;
  end

  cec_mbox_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .clr_wr_i (wr_i && addr_i == A_ISTAT),
    .clr_i    (wdata_i[EV_W-1:0]),
    .en_wr_i  (wr_i && addr_i == A_IEN),
    .en_i     (wdata_i),
    .stat_o   (irq_stat),
    .en_o     (irq_en),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_TXCTL: rdata_o = {tx_free, tx_ack, 6'b0} | 8'(tx_len_o);
      A_MODE:  rdata_o = mode_q;
      A_IEN:   rdata_o = irq_en;
      A_LADDR: rdata_o = laddr_q;
      A_ISTAT: rdata_o = 8'(irq_stat);
      A_RXCTL: rdata_o = {rx_valid, 7'b0} | 8'(rx_len);
      A_ID:    rdata_o = ID_VAL;
      A_PAH:   rdata_o = pa_q[15:8];
      A_PAL:   rdata_o = pa_q[7:0];
      default: if (in_rx) rdata_o = rx_byte;
    endcase
  end

  assign la_o = laddr_q[7:4];
endmodule

// File: rtl/cec_mbox_chk.sv
module cec_mbox_chk
  import cec_mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic [7:0] addr_i,
  input logic       irq_o,
  input ev_t        stat,
  input logic       tx_free,
  input logic       tx_req_o,
  input logic       tx_done_i,
  input logic       rx_valid,
  input logic       rx_commit_i
);
  logic rx_rd;
  assign rx_rd = rd_i && (addr_i >= A_RXBUF) && (addr_i < A_RXBUF + 8'(DEPTH));

  assert_req_not_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> !tx_free);

  assert_done_frees_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && tx_done_i) |=> (tx_free && stat[EV_TXDONE] && !tx_req_o));

  assert_commit_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid && rx_commit_i) |=> (rx_valid && stat[EV_RXMSG]));

  assert_clear_by_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_valid) |-> $past(rx_rd));

  assert_drop_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && rx_commit_i) |=> stat[EV_ERR]);

  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat != '0));
endmodule

bind cec_mbox_regs cec_mbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .addr_i      (addr_i),
  .irq_o       (irq_o),
  .stat        (irq_stat),
  .tx_free     (tx_free),
  .tx_req_o    (tx_req_o),
  .tx_done_i   (tx_done_i),
  .rx_valid    (rx_valid),
  .rx_commit_i (rx_commit_i)
);

// File: tb/cec_mbox_regs_test.sv
`timescale 1ns/100ps
module cec_mbox_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic wr = 1'b0, rd = 1'b0;
  logic irq, tx_req, tx_done = 1'b0, tx_ack = 1'b0;
  logic [3:0] la, tx_len, tx_idx = '0, rx_idx = '0, rx_len = '0;
  logic [7:0] tx_byte, rx_byte = '0;
  logic rx_wr = 1'b0, rx_commit = 1'b0;
  logic hpd_rise = 1'b0, hpd_fall = 1'b0, pa_upd = 1'b0;
  logic [15:0] pa = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cec_mbox_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .irq_o(irq), .la_o(la), .tx_req_o(tx_req), .tx_len_o(tx_len),
    .tx_idx_i(tx_idx), .tx_byte_o(tx_byte), .tx_done_i(tx_done), .tx_ack_i(tx_ack),
    .rx_wr_i(rx_wr), .rx_idx_i(rx_idx), .rx_byte_i(rx_byte), .rx_commit_i(rx_commit),
    .rx_len_i(rx_len), .hpd_rise_i(hpd_rise), .hpd_fall_i(hpd_fall),
    .pa_upd_i(pa_upd), .pa_i(pa)
  );

  task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input [7:0] a, input [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input [7:0] a, output [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input [7:0] a, output [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic rx_load(input [3:0] n, input [7:0] base);
    for (int i = 0; i <= int'(n); i++) begin
      @(negedge clk); rx_wr = 1'b1; rx_idx = 4'(i); rx_byte = base + 8'(i);
    end
    @(negedge clk); rx_wr = 1'b0; rx_commit = 1'b1; rx_len = n;
    @(negedge clk); rx_commit = 1'b0;
  endtask

  task automatic rx_drain();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) rd_reg(8'h41 + 8'(i), d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(8'h00, d); chk("R1 txctl", d, 8'h80);
    peek(8'h11, d); chk("R1 mode", d, 8'h78);
    peek(8'h1B, d); chk("R1 ien", d, 8'h80);
    peek(8'h3E, d); chk("R1 stat", d, 8'h00);
    peek(8'h40, d); chk("R1 rxctl", d, 8'h00);
    peek(8'h51, d); chk("R1 id", d, 8'h5B);
    peek(8'h34, d); chk("R1 laddr", d, 8'hF0);
    chk("R1 irq", irq, 0);
    chk("R1 txreq", tx_req, 0);
  endtask

  task automatic t_mode_gate();
    logic [7:0] d;
    wr_reg(8'h00, 8'h03);
    peek(8'h00, d); chk("R2 len write in auto mode", d, 8'h80);
    rx_load(4'd0, 8'h10);
    rx_drain();
    peek(8'h40, d); chk("R2 reads in auto mode keep flag", d, 8'h80);
    wr_reg(8'h11, 8'hB5);
    peek(8'h11, d); chk("R2 host mode", d, 8'hB5);
    rx_drain();
    peek(8'h40, d); chk("R7 drained in host mode", d, 8'h00);
    wr_reg(8'h3E, 8'h3F);
  endtask

  task automatic t_tx();
    logic [7:0] d;
    wr_reg(8'h00, 8'h02);
    peek(8'h00, d); chk("R3 len stored, busy", d, 8'h02);
    wr_reg(8'h01, 8'h11); chk("R3 no req after byte0", tx_req, 0);
    wr_reg(8'h02, 8'h22); chk("R3 no req after byte1", tx_req, 0);
    wr_reg(8'h03, 8'h33); chk("R3 req after last byte", tx_req, 1);
    chk("R3 tx_len", tx_len, 4'd2);
    tx_idx = 4'd1; #1 chk("R3 payload fetch", tx_byte, 8'h22);
    wr_reg(8'h00, 8'h0F);
    peek(8'h00, d); chk("R4 len write while busy", d, 8'h02);
    @(negedge clk); tx_done = 1'b1; tx_ack = 1'b1;
    @(negedge clk); tx_done = 1'b0; tx_ack = 1'b0;
    peek(8'h00, d); chk("R5 ctl after ack", d, 8'hC2);
    peek(8'h3E, d); chk("R5 txdone status", d & 8'h04, 8'h04);
    chk("R5 req dropped", tx_req, 0);
    wr_reg(8'h00, 8'h00);
    wr_reg(8'h01, 8'h5A); chk("R3 one-byte req", tx_req, 1);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    peek(8'h00, d); chk("R5 ctl after nack", d, 8'h80);
    wr_reg(8'h3E, 8'h3F);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    rx_load(4'd4, 8'hA0);
    peek(8'h40, d); chk("R6 rxctl", d, 8'h84);
    peek(8'h3E, d); chk("R6 rxmsg status", d & 8'h08, 8'h08);
    peek(8'h43, d); chk("R6 payload byte2", d, 8'hA2);
    for (int i = 0; i < 16; i++) rd_reg(8'h41, d);
    peek(8'h40, d); chk("R7 repeated read counts once", d, 8'h84);
    for (int i = 1; i < 15; i++) rd_reg(8'h41 + 8'(i), d);
    peek(8'h40, d); chk("R7 flag held after 15 locations", d, 8'h84);
    rd_reg(8'h50, d);
    peek(8'h40, d); chk("R7 flag cleared after 16", d, 8'h04);
    wr_reg(8'h3E, 8'h3F);
  endtask

  task automatic t_rx_drop();
    logic [7:0] d;
    rx_load(4'd1, 8'h55);
    rx_load(4'd7, 8'h99);
    peek(8'h40, d); chk("R8 pending length kept", d, 8'h81);
    peek(8'h41, d); chk("R8 pending byte kept", d, 8'h55);
    peek(8'h3E, d); chk("R8 error status", d & 8'h01, 8'h01);
    rx_drain();
    wr_reg(8'h3E, 8'h3F);
    peek(8'h3E, d); chk("R9 clear all", d, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk); hpd_rise = 1'b1;
    @(negedge clk); hpd_rise = 1'b0;
    peek(8'h3E, d); chk("R12 hpd rise bit4", d, 8'h10);
    wr_reg(8'h3E, 8'h01);
    peek(8'h3E, d); chk("R9 other bit clear no effect", d, 8'h10);
    wr_reg(8'h3E, 8'h10);
    peek(8'h3E, d); chk("R9 w1c", d, 8'h00);
    @(negedge clk); addr = 8'h3E; wdata = 8'h20; wr = 1'b1; hpd_fall = 1'b1;
    @(negedge clk); wr = 1'b0; hpd_fall = 1'b0;
    peek(8'h3E, d); chk("R9 set wins over clear", d, 8'h20);
  endtask

  task automatic t_irq();
    chk("R10 masked by 0x80", irq, 0);
    wr_reg(8'h1B, 8'hFF); chk("R10 enabled", irq, 1);
    wr_reg(8'h1B, 8'h10); chk("R10 other source only", irq, 0);
    wr_reg(8'h1B, 8'h20); chk("R10 own source", irq, 1);
    wr_reg(8'h3E, 8'h20); chk("R10 after clear", irq, 0);
    wr_reg(8'h1B, 8'h80);
  endtask

  task automatic t_laddr_pa();
    logic [7:0] d;
    wr_reg(8'h34, 8'h3C);
    peek(8'h34, d); chk("R11 low nibble kept", d, 8'h30);
    chk("R11 la_o", la, 4'h3);
    @(negedge clk); pa = 16'h1234; pa_upd = 1'b1;
    @(negedge clk); pa_upd = 1'b0;
    peek(8'h53, d); chk("R12 pa high", d, 8'h12);
    peek(8'h54, d); chk("R12 pa low", d, 8'h34);
    peek(8'h3E, d); chk("R12 newpa status", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_gate();
    t_tx();
    t_rx();
    t_rx_drop();
    t_status();
    t_irq();
    t_laddr_pa();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule